// File: doc/BRIEF.md
# Card Host Status and Interrupt Register

This block holds the event status word of a memory-card host controller and turns it into one interrupt line. The command path, the data-buffer path and the card-detect logic each signal an event with a one-cycle pulse. The pulse sets a sticky bit that stays set until a bus master writes a one to that bit position. A second register holds interrupt enables. The enables are laid out in their own bit order, not in the order of the status bits. The interrupt output is the registered OR of every enabled status source.

Some status bits are not sticky: buffer empty/full flags, buffer ready flags, the SDIO interrupt line and the card clock indication. These show live inputs every cycle. A 2-bit write-CRC status code is captured together with the write CRC error event. A combinational summary flag reports whether any error bit is set.

The register port is simple. `bus_addr` 0 selects the status word and 1 selects the enable word. Read data is combinational, and writes take effect on the clock edge. A driver reads the status word and writes the same value back. This acknowledges exactly the events it has seen.

Top module: `hsr_status_top`

## Requirements
- R1: A one-cycle event pulse sets its sticky status bit at the next clock edge: card inserted 31, card removed 30, buffer underrun 25, buffer overflow 24, command response ended 13, write finished 12, read/transfer finished 11, response CRC error 5, read CRC error 3, write CRC error 2, response timeout 1, read timeout 0.
- R2: A write to address 0 clears every sticky bit written as 1 and leaves bits written as 0 unchanged. Writing back the value just read clears exactly the set bits.
- R3: If an event pulse and a clearing write of the same bit occur in the same cycle, the bit is set after the edge.
- R4: Level bits follow their inputs in the same cycle, and writes do not affect them: Y empty 29, X empty 28, Y full 27, X full 26, SDIO interrupt 14, card clock running 8, buffer readable 7, buffer writable 6.
- R5: Bits 10:9 load the 2-bit write-CRC code whenever the write CRC error event pulses, replacing the old code. Code 2 (bit 10 set, bit 9 clear) means no CRC status came back. A write of ones clears the code bits.
- R6: `err_any` is high exactly when any of status bits 5, 3, 2, 1 or 0 is set (mask 0x2F).
- R7: Address 1 holds the enable word. Only bits 0–4, 12–18 (mask 0x0007F01F) are stored, and the other bits read 0.
- R8: The enable-to-status pairs are: enable 0 to status 11, 1 to 12, 2 to 13, 3 to 6, 4 to 7, 13 to 14, 14 to 30, 15 to 31. `irq` is registered and goes high one edge after an enabled pair becomes true. It goes low one edge after no pair is true.
- R9: Reset clears all sticky bits, the enable word and `irq`.
- R10: Status bits 23–15 and 4 always read 0, even after a write of ones.
- R11: Enable bits 12 and 16–18 have no status partner, and setting them never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_addr | input | 1 | 0 status word, 1 enable word |
| bus_wr | input | 1 | write strobe |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data of selected word |
| card_ins_ev | input | 1 | card inserted pulse |
| card_rem_ev | input | 1 | card removed pulse |
| buf_under_ev | input | 1 | buffer underrun pulse |
| buf_over_ev | input | 1 | buffer overflow pulse |
| cmd_resp_ev | input | 1 | command response ended pulse |
| wr_done_ev | input | 1 | write finished pulse |
| rd_done_ev | input | 1 | read/transfer finished pulse |
| resp_crc_ev | input | 1 | response CRC error pulse |
| rd_crc_ev | input | 1 | read CRC error pulse |
| wr_crc_ev | input | 1 | write CRC error pulse |
| wr_crc_code | input | 2 | write CRC code, sampled with wr_crc_ev |
| resp_to_ev | input | 1 | response timeout pulse |
| rd_to_ev | input | 1 | read timeout pulse |
| ybuf_empty_lvl | input | 1 | Y buffer empty |
| xbuf_empty_lvl | input | 1 | X buffer empty |
| ybuf_full_lvl | input | 1 | Y buffer full |
| xbuf_full_lvl | input | 1 | X buffer full |
| sdio_int_lvl | input | 1 | SDIO interrupt active |
| clk_run_lvl | input | 1 | card clock running |
| rd_rdy_lvl | input | 1 | buffer ready to read |
| wr_rdy_lvl | input | 1 | buffer ready to write |
| irq | output | 1 | registered interrupt |
| err_any | output | 1 | any error bit set |

## Verification
A sticky bit that is lost, kept too long or cleared by the wrong write data shows up on `bus_rdata` at the next read, one edge after the event or write. A wrong enable pairing shows up on `irq` one edge after the status bit changes. The bench therefore reads back after every stimulus and checks `irq` with one extra edge of delay. The same-cycle race between an event and a clear, the replacement of the CRC code, and enables that have no partner each get a directed case.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
    localparam int unsigned DW = 32;
    // bits holding edge-captured state
    localparam logic [DW-1:0] STICKY_MASK = 32'hC300_3E2F;
    // bits following live inputs
    localparam logic [DW-1:0] LEVEL_MASK  = 32'h3C00_41C0;
    localparam logic [DW-1:0] ERR_MASK    = 32'h0000_002F;
    localparam logic [DW-1:0] IEN_MASK    = 32'h0007_F01F;
    localparam int unsigned CODE_LO = 9;
    localparam int unsigned CODE_W  = 2;
    localparam int unsigned NSRC    = 8;
    // enable bit -> status bit pairs
    localparam int unsigned EN_POS   [NSRC] = '{0, 1, 2, 3, 4, 13, 14, 15};
    localparam int unsigned STAT_POS [NSRC] = '{11, 12, 13, 6, 7, 14, 30, 31};
endpackage

// File: rtl/hsr_sticky_bank.sv
module hsr_sticky_bank #(
    parameter int unsigned WIDTH = 32,
    parameter logic [WIDTH-1:0] KEEP_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    input  logic [WIDTH-1:0] load_vec,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] bits_q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (KEEP_MASK[b]) begin : g_keep
            logic cell_q;
            always_ff @(posedge clk) begin
                if (!rst_n)           cell_q <= 1'b0;
                else if (load_vec[b]) cell_q <= load_val[b];
                else if (set_vec[b])  cell_q <= 1'b1;  // event beats clear
                else if (clr_vec[b])  cell_q <= 1'b0;
            end
            assign bits_q[b] = cell_q;
        end else begin : g_none
            assign bits_q[b] = 1'b0;
        end
    end
endmodule

// File: rtl/hsr_irq_gen.sv
module hsr_irq_gen #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    input  logic [N-1:0] en,
    output logic         irq
);
    logic irq_q;
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(src & en);
    end
    assign irq = irq_q;
endmodule

// File: rtl/hsr_status_top.sv
module hsr_status_top
    import hsr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          card_ins_ev,
    input  logic          card_rem_ev,
    input  logic          buf_under_ev,
    input  logic          buf_over_ev,
    input  logic          cmd_resp_ev,
    input  logic          wr_done_ev,
    input  logic          rd_done_ev,
    input  logic          resp_crc_ev,
    input  logic          rd_crc_ev,
    input  logic          wr_crc_ev,
    input  logic [1:0]    wr_crc_code,
    input  logic          resp_to_ev,
    input  logic          rd_to_ev,
    input  logic          ybuf_empty_lvl,
    input  logic          xbuf_empty_lvl,
    input  logic          ybuf_full_lvl,
    input  logic          xbuf_full_lvl,
    input  logic          sdio_int_lvl,
    input  logic          clk_run_lvl,
    input  logic          rd_rdy_lvl,
    input  logic          wr_rdy_lvl,
    output logic          irq,
    output logic          err_any
);
    localparam logic [DW-1:0] CODE_FIELD = ((DW'(1) << CODE_W) - 1) << CODE_LO;

    logic [DW-1:0] set_vec, clr_vec, load_vec, load_val;
    logic [DW-1:0] sticky_q, live_word, status_word;
    logic [DW-1:0] ien;
    logic [NSRC-1:0] src_sel, en_sel;

    always_comb begin
        set_vec     = '0;
        set_vec[31] = card_ins_ev;
        set_vec[30] = card_rem_ev;
        set_vec[25] = buf_under_ev;
        set_vec[24] = buf_over_ev;
        set_vec[13] = cmd_resp_ev;
        set_vec[12] = wr_done_ev;
        set_vec[11] = rd_done_ev;
        set_vec[5]  = resp_crc_ev;
        set_vec[3]  = rd_crc_ev;
        set_vec[2]  = wr_crc_ev;
        set_vec[1]  = resp_to_ev;
        set_vec[0]  = rd_to_ev;
    end

    always_comb begin
        live_word     = '0;
        live_word[29] = ybuf_empty_lvl;
        live_word[28] = xbuf_empty_lvl;
        live_word[27] = ybuf_full_lvl;
        live_word[26] = xbuf_full_lvl;
        live_word[14] = sdio_int_lvl;
        live_word[8]  = clk_run_lvl;
        live_word[7]  = rd_rdy_lvl;
        live_word[6]  = wr_rdy_lvl;
    end

    assign clr_vec  = (bus_wr && !bus_addr) ? (bus_wdata & STICKY_MASK) : '0;
    assign load_vec = wr_crc_ev ? CODE_FIELD : '0;
    assign load_val = DW'(wr_crc_code) << CODE_LO;

    hsr_sticky_bank #(.WIDTH(DW), .KEEP_MASK(STICKY_MASK)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .load_vec (load_vec),
        .load_val (load_val),
        .bits_q   (sticky_q)
    );

    assign status_word = sticky_q | (live_word & LEVEL_MASK);

    always_ff @(posedge clk) begin
        if (!rst_n)                  ien <= '0;
        else if (bus_wr && bus_addr) ien <= bus_wdata & IEN_MASK;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_pair
        assign src_sel[i] = status_word[STAT_POS[i]];
        assign en_sel[i]  = ien[EN_POS[i]];
    end

    hsr_irq_gen #(.N(NSRC)) irq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src_sel),
        .en    (en_sel),
        .irq   (irq)
    );

    assign err_any   = |(sticky_q & ERR_MASK);
    assign bus_rdata = bus_addr ? ien : status_word;
endmodule

// File: rtl/hsr_status_chk.sv
module hsr_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        stat_wr,
    input logic        wd31,
    input logic        wd13,
    input logic        card_ins_ev,
    input logic        cmd_resp_ev,
    input logic        rd_to_ev,
    input logic        rd_rdy_lvl,
    input logic        ien_rd,
    input logic [31:0] status_word,
    input logic        irq,
    input logic        err_any
);
    // R1
    ins_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_ins_ev |=> status_word[31]);
    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_resp_ev && stat_wr && wd13) |=> status_word[13]);
    // R2
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wd31 && !card_ins_ev) |=> !status_word[31]);
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[31] && !(stat_wr && wd31)) |=> status_word[31]);
    // R6
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_to_ev |=> err_any);
    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rdy_lvl && ien_rd) |=> irq);
endmodule

bind hsr_status_top hsr_status_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .stat_wr     (bus_wr && !bus_addr),
    .wd31        (bus_wdata[31]),
    .wd13        (bus_wdata[13]),
    .card_ins_ev (card_ins_ev),
    .cmd_resp_ev (cmd_resp_ev),
    .rd_to_ev    (rd_to_ev),
    .rd_rdy_lvl  (rd_rdy_lvl),
    .ien_rd      (ien[4]),
    .status_word (status_word),
    .irq         (irq),
    .err_any     (err_any)
);

// File: tb/hsr_status_top_tb_top.sv
`timescale 1ns/1ps
module hsr_status_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_addr = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] ev = '0, lv = '0;
    logic irq, err_any;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    hsr_status_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .card_ins_ev(ev[31]), .card_rem_ev(ev[30]), .buf_under_ev(ev[25]),
        .buf_over_ev(ev[24]), .cmd_resp_ev(ev[13]), .wr_done_ev(ev[12]),
        .rd_done_ev(ev[11]), .resp_crc_ev(ev[5]), .rd_crc_ev(ev[3]),
        .wr_crc_ev(ev[2]), .wr_crc_code(ev[10:9]), .resp_to_ev(ev[1]),
        .rd_to_ev(ev[0]), .ybuf_empty_lvl(lv[29]), .xbuf_empty_lvl(lv[28]),
        .ybuf_full_lvl(lv[27]), .xbuf_full_lvl(lv[26]), .sdio_int_lvl(lv[14]),
        .clk_run_lvl(lv[8]), .rd_rdy_lvl(lv[7]), .wr_rdy_lvl(lv[6]),
        .irq(irq), .err_any(err_any)
    );

    // ops: 0 write, 1 read+compare, 2 event pulse, 3 set levels, 4 irq check, 5 err check
    localparam int NV = 34;
    localparam logic [67:0] VEC [NV] = '{
        {3'd1, 1'b0, 32'h0,          32'h0},          // R9 status
        {3'd1, 1'b1, 32'h0,          32'h0},          // R9 enables
        {3'd4, 1'b0, 32'h0,          32'h0},          // R9 irq
        {3'd2, 1'b0, 32'h8000_2001,  32'h0},
        {3'd1, 1'b0, 32'h0,          32'h8000_2001},  // R1
        {3'd5, 1'b0, 32'h0,          32'h1},          // R6
        {3'd0, 1'b0, 32'h0000_2000,  32'h0},
        {3'd1, 1'b0, 32'h0,          32'h8000_0001},  // R2 partial
        {3'd0, 1'b0, 32'h8000_0001,  32'h0},
        {3'd1, 1'b0, 32'h0,          32'h0},          // R2 read-back clear
        {3'd5, 1'b0, 32'h0,          32'h0},          // R6 low
        {3'd2, 1'b0, 32'h4300_1822,  32'h0},
        {3'd1, 1'b0, 32'h0,          32'h4300_1822},  // R1 others
        {3'd0, 1'b0, 32'hFFFF_FFFF,  32'h0},
        {3'd1, 1'b0, 32'h0,          32'h0},          // R10, R2
        {3'd0, 1'b1, 32'hFFFF_FFFF,  32'h0},
        {3'd1, 1'b1, 32'h0,          32'h0007_F01F},  // R7
        {3'd4, 1'b0, 32'h0,          32'h0},          // R8 nothing pending
        {3'd3, 1'b0, 32'h0000_0080,  32'h0},
        {3'd1, 1'b0, 32'h0,          32'h0000_0080},  // R4
        {3'd4, 1'b0, 32'h0,          32'h1},          // R8
        {3'd0, 1'b0, 32'h0000_0080,  32'h0},
        {3'd1, 1'b0, 32'h0,          32'h0000_0080},  // R4 write ignored
        {3'd3, 1'b0, 32'h3C00_4140,  32'h0},
        {3'd1, 1'b0, 32'h0,          32'h3C00_4140},  // R4 all levels
        {3'd3, 1'b0, 32'h0,          32'h0},
        {3'd4, 1'b0, 32'h0,          32'h0},          // R8 falls
        {3'd2, 1'b0, 32'h0000_0404,  32'h0},
        {3'd1, 1'b0, 32'h0,          32'h0000_0404},  // R5 code 2
        {3'd2, 1'b0, 32'h0000_0204,  32'h0},
        {3'd1, 1'b0, 32'h0,          32'h0000_0204},  // R5 replaced
        {3'd0, 1'b1, 32'h0007_1000,  32'h0},
        {3'd2, 1'b0, 32'hC000_0000,  32'h0},
        {3'd4, 1'b0, 32'h0,          32'h0}           // R11
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic do_read(input string req, input logic a, input logic [31:0] exp);
        @(negedge clk); bus_addr = a; #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic do_pulse(input logic [31:0] m);
        @(negedge clk); ev = m;
        @(negedge clk); ev = '0;
    endtask

    task automatic do_irq(input string req, input logic exp);
        @(negedge clk); @(negedge clk);
        check(req, {31'd0, irq}, {31'd0, exp});
    endtask

    initial begin : watchdog
        #(5ns * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][67:65])
                3'd0: do_write(VEC[i][64], VEC[i][63:32]);
                3'd1: do_read($sformatf("vec%0d R1-group", i), VEC[i][64], VEC[i][31:0]);
                3'd2: do_pulse(VEC[i][63:32]);
                3'd3: begin @(negedge clk); lv = VEC[i][63:32]; end
                3'd4: do_irq($sformatf("vec%0d irq R8", i), VEC[i][0]);
                default: begin @(negedge clk); check($sformatf("vec%0d err R6", i), {31'd0, err_any}, VEC[i][31:0]); end
            endcase
        end
        // R11: the removal/insertion bits are set but their enables are off
        do_read("R11 status kept", 1'b0, 32'hC000_0204);
        // R8: the insertion enable alone raises irq
        do_write(1'b1, 32'h0000_8000);
        do_irq("R8 insertion", 1'b1);
        do_write(1'b0, 32'hFFFF_FFFF);
        do_irq("R8 cleared", 1'b0);
        // R3: event and clear of the same bit in one cycle
        @(negedge clk); bus_addr = 1'b0; bus_wr = 1'b1; bus_wdata = 32'h0000_2000; ev = 32'h0000_2000;
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0; ev = '0;
        do_read("R3 set wins", 1'b0, 32'h0000_2000);
        // R9: reset during activity
        do_write(1'b1, 32'h0000_0004);
        do_irq("R9 pre-reset irq", 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R9 irq after reset", {31'd0, irq}, 32'd0);
        do_read("R9 status after reset", 1'b0, 32'h0);
        do_read("R9 enable after reset", 1'b1, 32'h0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule